// File: doc/BRIEF.md
# Per-Thread Instruction Fetch Line Buffer

This block holds instruction cache lines for a single hardware thread group in a small ring of line-sized slots. All slots sit inside one word-addressed storage array. After a redirect, the block asks memory for consecutive lines, starting at the line that holds the branch target. It keeps one slot per line and marks that slot as reserved until the fill data for it returns. Fills must arrive in request order. A fill whose tag belongs to a flushed request is discarded without any error.

The decoder side sees one instruction at a time, either one or two 32-bit words long. The decoder consumes it with a ready/valid pair. A two-word instruction may cross a line boundary, and it may also cross the physical end of the storage array. The thread's program counter is fed back to the block. Once the program counter has left the oldest line and decoding has moved past that line, the slot is released and can be refilled.

Top module: `ifb_line_buffer`

## Requirements
- R1: After reset the block is idle: `req_valid_o`, `dec_valid_o`, `data_avail_o` and `fill_err_o` are 0, and `occupancy_o` and `bytes_left_o` are 0. It stays idle until the first flush.
- R2: A line request is offered only while fewer than DEPTH lines are reserved or buffered. The first request after a flush is for the target rounded down to a line boundary. Each later request is for the line that follows the youngest reserved or buffered line.
- R3: A fill with the current tag and the address of the oldest reserved line turns that line into a buffered line. Word w of `fill_data_i` (bits 32w+31 down to 32w) is the instruction word at line address + 4w.
- R4: A fill with the current tag whose address is not the oldest reserved line raises `fill_err_o` for exactly one cycle, on the cycle after the fill is sampled. It changes neither the occupancy nor the data.
- R5: `occupancy_o` equals the number of buffered lines plus the number of reserved lines, and it never exceeds DEPTH.
- R6: `bytes_left_o` equals the buffered bytes (buffered lines times LINE_BYTES) minus the bytes already decoded from the oldest buffered line's start, and is never below 0. `data_avail_o` is 1 exactly when `bytes_left_o` is non-zero.
- R7: Bit 0 of an instruction's first word set to 1 marks a two-word instruction, and set to 0 marks a one-word instruction. `dec_valid_o` is raised only when every word of the instruction is buffered. A consume advances the read point by the instruction's length.
- R8: Slots wrap around the array: the word after the last word of the last slot is the first word of slot 0. A two-word instruction whose first word is the last word of the array is presented whole, with its second word taken from slot 0.
- R9: The oldest buffered line is released, at most one per cycle, when three conditions hold: `pc_i` lies in a later line, decoding has passed the end of that line, and no flush is active. Its slot then becomes free for a new request.
- R10: A flush discards every reserved and buffered line and advances the request tag by one. Slot allocation restarts at slot 0, and decoding restarts at the target's word within its line.
- R11: A fill whose tag differs from the current tag is dropped: no error, no change to occupancy or data.
- R12: `dec_pc_o` is the byte address of the instruction currently presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush_i | input | 1 | Redirect: discard contents and restart at `flush_pc_i` |
| flush_pc_i | input | AW | Branch target byte address |
| pc_i | input | AW | Current thread program counter |
| req_valid_o | output | 1 | Line request offered |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | AW | Line-aligned request address |
| req_tag_o | output | EW | Tag that the matching fill must echo |
| fill_valid_i | input | 1 | Fill data present |
| fill_addr_i | input | AW | Line address of the fill |
| fill_tag_i | input | EW | Tag echoed from the request |
| fill_data_i | input | 8*LINE_BYTES | Line data, word w at bits 32w+31:32w |
| dec_valid_o | output | 1 | A whole instruction is presented |
| dec_ready_i | input | 1 | Decoder consumes the instruction |
| dec_pc_o | output | AW | Address of the presented instruction |
| dec_word0_o | output | 32 | First instruction word |
| dec_word1_o | output | 32 | Second word (meaningful when `dec_len2_o`) |
| dec_len2_o | output | 1 | Presented instruction is two words long |
| occupancy_o | output | clog2(DEPTH+1) | Reserved plus buffered lines |
| bytes_left_o | output | clog2(DEPTH*LINE_BYTES/4+1)+2 | Fetched bytes not yet decoded |
| data_avail_o | output | 1 | Undecoded bytes exist |
| fill_err_o | output | 1 | Out-of-order fill seen on the previous cycle |

## Verification
The assertions rely on three assumptions about the inputs:
- The program counter fed back never runs ahead of the instructions actually consumed.
- Fills carrying the current tag come back in request order unless an error is being provoked deliberately.
- A flush is applied only while the decoder is stalled.

The stimulus keeps to these assumptions as follows. The bench drives `pc_i` from the address after each consumed instruction, and its memory model answers recorded requests strictly in order. It lowers `dec_ready_i` a few cycles before each redirect. The only misordered fills are the single injected wrong-address fill and the fill with a stale tag.

// File: rtl/ifb_pkg.sv
package ifb_pkg;

  localparam int unsigned WORD_BYTES = 4;

  // Words still to decode, floored at zero.
  function automatic int unsigned words_left(int unsigned lines, int unsigned wpl,
                                             int unsigned off);
    int unsigned have;
    have = lines * wpl;
    return (have > off) ? (have - off) : 0;
  endfunction

  // Length of an instruction in words, from its first word.
  function automatic int unsigned insn_words(logic len_bit);
    return len_bit ? 2 : 1;
  endfunction

endpackage

// File: rtl/ifb_slot_ctrl.sv
module ifb_slot_ctrl #(
  parameter int DEPTH      = 4,
  parameter int LINE_BYTES = 16,
  parameter int AW         = 32,
  parameter int EW         = 2,
  parameter int ROFF_W     = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_i,
  input  logic [AW-1:0]                flush_pc_i,
  input  logic [AW-1:0]                pc_i,
  input  logic [ROFF_W-1:0]            rd_off_i,
  input  logic                         req_ready_i,
  input  logic                         fill_valid_i,
  input  logic [AW-1:0]                fill_addr_i,
  input  logic [EW-1:0]                fill_tag_i,
  output logic                         req_valid_o,
  output logic [AW-1:0]                req_addr_o,
  output logic [EW-1:0]                req_tag_o,
  output logic [$clog2(DEPTH)-1:0]     head_o,
  output logic [$clog2(DEPTH)-1:0]     fill_slot_o,
  output logic                         fill_ok_o,
  output logic [$clog2(DEPTH+1)-1:0]   alloc_o,
  output logic [$clog2(DEPTH+1)-1:0]   nbuf_o,
  output logic [AW-1:0]                base_o,
  output logic                         release_o,
  output logic                         err_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int LB_SH = $clog2(LINE_BYTES);
  localparam int WPL   = LINE_BYTES / ifb_pkg::WORD_BYTES;

  logic             run_q, err_q;
  logic [IDX_W-1:0] head_q;
  logic [CNT_W-1:0] alloc_q, nbuf_q;
  logic [AW-1:0]    base_q;
  logic [EW-1:0]    tag_q;

  logic             issue, tag_hit, fill_ok, fill_bad, rel;
  logic [AW-1:0]    exp_fill_addr;
  logic             unused_bits;

  assign unused_bits   = ^{pc_i[LB_SH-1:0]};
  assign req_valid_o   = run_q && (alloc_q < CNT_W'(DEPTH));
  assign req_addr_o    = base_q + (AW'(alloc_q) << LB_SH);
  assign req_tag_o     = tag_q;
  assign issue         = req_valid_o && req_ready_i;
  assign exp_fill_addr = base_q + (AW'(nbuf_q) << LB_SH);
  assign tag_hit       = run_q && fill_valid_i && (fill_tag_i == tag_q);
  assign fill_ok       = tag_hit && (alloc_q > nbuf_q) && (fill_addr_i == exp_fill_addr);
  assign fill_bad      = tag_hit && !fill_ok;
  assign rel           = run_q && !flush_i && (nbuf_q != '0) &&
                         (rd_off_i >= ROFF_W'(WPL)) &&
                         (pc_i[AW-1:LB_SH] > base_q[AW-1:LB_SH]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      err_q   <= 1'b0;
      head_q  <= '0;
      alloc_q <= '0;
      nbuf_q  <= '0;
      base_q  <= '0;
      tag_q   <= '0;
    end else if (flush_i) begin
      run_q   <= 1'b1;
      err_q   <= 1'b0;
      head_q  <= '0;
      alloc_q <= '0;
      nbuf_q  <= '0;
      base_q  <= {flush_pc_i[AW-1:LB_SH], LB_SH'(0)};
      tag_q   <= tag_q + EW'(1);
    end else begin
      err_q   <= fill_bad;
      alloc_q <= alloc_q + CNT_W'(issue) - CNT_W'(rel);
      nbuf_q  <= nbuf_q + CNT_W'(fill_ok) - CNT_W'(rel);
      if (rel) begin
        head_q <= head_q + IDX_W'(1);
        base_q <= base_q + (AW'(1) << LB_SH);
      end
    end
  end

  assign head_o      = head_q;
  assign fill_slot_o = head_q + IDX_W'(nbuf_q);
  assign fill_ok_o   = fill_ok;
  assign alloc_o     = alloc_q;
  assign nbuf_o      = nbuf_q;
  assign base_o      = base_q;
  assign release_o   = rel;
  assign err_o       = err_q;

  // R5: reserved plus buffered lines stay within the ring
  assert_occ_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_q <= CNT_W'(DEPTH)) && (nbuf_q <= alloc_q));

  // R2: an accepted request adds exactly one line to the occupancy
  assert_req_adds_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !flush_i && !rel) |=> (alloc_q == $past(alloc_q) + CNT_W'(1)));

  // R3: an in-order fill turns one reservation into a buffered line
  assert_fill_buffers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ok && !flush_i && !rel) |=> (nbuf_q == $past(nbuf_q) + CNT_W'(1)));

  // R4: the error flag only ever follows a sampled fill
  assert_err_after_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(fill_valid_i));

  // R11: a fill with an old tag never raises the error flag
  assert_stale_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_i && (fill_tag_i != tag_q) && !flush_i) |=> !err_q);

  // R10: a flush empties the ring
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> ((alloc_q == '0) && (nbuf_q == '0) && (head_q == '0)));

endmodule

// File: rtl/ifb_store.sv
module ifb_store #(
  parameter int DEPTH      = 4,
  parameter int LINE_BYTES = 16
) (
  input  logic                                         clk,
  input  logic                                         we_i,
  input  logic [$clog2(DEPTH)-1:0]                     slot_i,
  input  logic [8*LINE_BYTES-1:0]                      line_i,
  input  logic [$clog2(DEPTH*LINE_BYTES/4)-1:0]        ridx0_i,
  input  logic [$clog2(DEPTH*LINE_BYTES/4)-1:0]        ridx1_i,
  output logic [31:0]                                  rdata0_o,
  output logic [31:0]                                  rdata1_o
);
  localparam int WPL    = LINE_BYTES / ifb_pkg::WORD_BYTES;
  localparam int WOFF_W = $clog2(WPL);
  localparam int TOTAL  = DEPTH * WPL;

  logic [31:0] mem [TOTAL];

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int w = 0; w < WPL; w++) begin
        mem[{slot_i, WOFF_W'(w)}] <= line_i[32*w +: 32];
      end
    end
  end

  assign rdata0_o = mem[ridx0_i];
  assign rdata1_o = mem[ridx1_i];

endmodule

// File: rtl/ifb_read_ctrl.sv
module ifb_read_ctrl #(
  parameter int DEPTH      = 4,
  parameter int LINE_BYTES = 16,
  parameter int ROFF_W     = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  flush_i,
  input  logic [$clog2(LINE_BYTES/4)-1:0]       flush_off_i,
  input  logic [$clog2(DEPTH)-1:0]              head_i,
  input  logic [$clog2(DEPTH+1)-1:0]            nbuf_i,
  input  logic                                  release_i,
  input  logic                                  len_bit_i,
  input  logic                                  dec_ready_i,
  output logic [ROFF_W-1:0]                     rd_off_o,
  output logic [ROFF_W-1:0]                     avail_o,
  output logic [$clog2(DEPTH*LINE_BYTES/4)-1:0] ridx0_o,
  output logic [$clog2(DEPTH*LINE_BYTES/4)-1:0] ridx1_o,
  output logic                                  dec_valid_o,
  output logic                                  dec_len2_o
);
  localparam int WPL    = LINE_BYTES / ifb_pkg::WORD_BYTES;
  localparam int WOFF_W = $clog2(WPL);
  localparam int WIDX_W = $clog2(DEPTH * WPL);

  logic [ROFF_W-1:0] rd_off_q;
  logic [ROFF_W-1:0] step;
  logic              consume;

  assign avail_o     = ROFF_W'(ifb_pkg::words_left(int'(nbuf_i), WPL, int'(rd_off_q)));
  assign ridx0_o     = {head_i, WOFF_W'(0)} + WIDX_W'(rd_off_q);
  assign ridx1_o     = ridx0_o + WIDX_W'(1);
  assign dec_len2_o  = len_bit_i;
  assign dec_valid_o = (avail_o != '0) && (!len_bit_i || (avail_o >= ROFF_W'(2)));
  assign consume     = dec_valid_o && dec_ready_i;
  assign step        = consume ? ROFF_W'(ifb_pkg::insn_words(len_bit_i)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_off_q <= '0;
    else if (flush_i)   rd_off_q <= ROFF_W'(flush_off_i);
    else                rd_off_q <= rd_off_q + step - (release_i ? ROFF_W'(WPL) : '0);
  end

  assign rd_off_o = rd_off_q;

  // R7: a consume moves the read point by the instruction length
  assert_consume_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !flush_i && !release_i) |=>
      (rd_off_q == $past(rd_off_q) + ($past(len_bit_i) ? ROFF_W'(2) : ROFF_W'(1))));

  // R10: decoding restarts at the target word after a flush
  assert_flush_offset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (rd_off_q == ROFF_W'($past(flush_off_i))));

endmodule

// File: rtl/ifb_line_buffer.sv
module ifb_line_buffer #(
  parameter int DEPTH      = 4,
  parameter int LINE_BYTES = 16,
  parameter int AW         = 32,
  parameter int EW         = 2
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       flush_i,
  input  logic [AW-1:0]                              flush_pc_i,
  input  logic [AW-1:0]                              pc_i,
  output logic                                       req_valid_o,
  input  logic                                       req_ready_i,
  output logic [AW-1:0]                              req_addr_o,
  output logic [EW-1:0]                              req_tag_o,
  input  logic                                       fill_valid_i,
  input  logic [AW-1:0]                              fill_addr_i,
  input  logic [EW-1:0]                              fill_tag_i,
  input  logic [8*LINE_BYTES-1:0]                    fill_data_i,
  output logic                                       dec_valid_o,
  input  logic                                       dec_ready_i,
  output logic [AW-1:0]                              dec_pc_o,
  output logic [31:0]                                dec_word0_o,
  output logic [31:0]                                dec_word1_o,
  output logic                                       dec_len2_o,
  output logic [$clog2(DEPTH+1)-1:0]                 occupancy_o,
  output logic [$clog2(DEPTH*LINE_BYTES/4+1)+1:0]    bytes_left_o,
  output logic                                       data_avail_o,
  output logic                                       fill_err_o
);
  localparam int WPL     = LINE_BYTES / ifb_pkg::WORD_BYTES;
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int WIDX_W  = $clog2(DEPTH * WPL);
  localparam int ROFF_W  = $clog2(DEPTH * WPL + 1);
  localparam int BYTES_W = ROFF_W + 2;
  localparam int LB_SH   = $clog2(LINE_BYTES);

  logic [IDX_W-1:0]  head, fill_slot;
  logic [CNT_W-1:0]  alloc, nbuf;
  logic [AW-1:0]     base;
  logic              fill_ok, rel;
  logic [ROFF_W-1:0] rd_off, avail;
  logic [WIDX_W-1:0] ridx0, ridx1;
  logic [31:0]       rdata0, rdata1;
  logic              unused_bits;

  assign unused_bits = ^{flush_pc_i[1:0]};

  ifb_slot_ctrl #(.DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES), .AW(AW), .EW(EW),
                  .ROFF_W(ROFF_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_pc_i(flush_pc_i),
    .pc_i(pc_i), .rd_off_i(rd_off), .req_ready_i(req_ready_i),
    .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i), .fill_tag_i(fill_tag_i),
    .req_valid_o(req_valid_o), .req_addr_o(req_addr_o), .req_tag_o(req_tag_o),
    .head_o(head), .fill_slot_o(fill_slot), .fill_ok_o(fill_ok),
    .alloc_o(alloc), .nbuf_o(nbuf), .base_o(base), .release_o(rel),
    .err_o(fill_err_o)
  );

  ifb_store #(.DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES)) u_store (
    .clk(clk), .we_i(fill_ok && !flush_i), .slot_i(fill_slot), .line_i(fill_data_i),
    .ridx0_i(ridx0), .ridx1_i(ridx1), .rdata0_o(rdata0), .rdata1_o(rdata1)
  );

  ifb_read_ctrl #(.DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES), .ROFF_W(ROFF_W)) u_read (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .flush_off_i(flush_pc_i[LB_SH-1:2]), .head_i(head), .nbuf_i(nbuf),
    .release_i(rel), .len_bit_i(rdata0[0]), .dec_ready_i(dec_ready_i),
    .rd_off_o(rd_off), .avail_o(avail), .ridx0_o(ridx0), .ridx1_o(ridx1),
    .dec_valid_o(dec_valid_o), .dec_len2_o(dec_len2_o)
  );

  assign dec_pc_o     = base + (AW'(rd_off) << 2);
  assign dec_word0_o  = rdata0;
  assign dec_word1_o  = rdata1;
  assign occupancy_o  = alloc;
  assign bytes_left_o = BYTES_W'({avail, 2'b00});
  assign data_avail_o = (avail != '0);

  // R6: an instruction is only ever presented with undecoded bytes counted
  assert_valid_has_bytes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> (bytes_left_o >= (dec_len2_o ? BYTES_W'(8) : BYTES_W'(4))));

  // R9: a release frees one line without a flush
  assert_release_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !req_valid_o) |=> (occupancy_o == $past(occupancy_o) - CNT_W'(1)));

endmodule

// File: tb/ifb_line_buffer_bench.sv
module ifb_line_buffer_bench;
  localparam int DEPTH = 4, LINE_BYTES = 16, AW = 32, EW = 2;

  logic clk = 0, rst_n = 0;
  logic flush_i = 0;
  logic [AW-1:0] flush_pc_i = '0, pc_i;
  logic req_valid_o, req_ready_i = 1'b1;
  logic [AW-1:0] req_addr_o;
  logic [EW-1:0] req_tag_o;
  logic fill_valid_i;
  logic [AW-1:0] fill_addr_i;
  logic [EW-1:0] fill_tag_i;
  logic [8*LINE_BYTES-1:0] fill_data_i;
  logic dec_valid_o, dec_ready_i, dec_len2_o;
  logic [AW-1:0] dec_pc_o;
  logic [31:0] dec_word0_o, dec_word1_o;
  logic [2:0] occupancy_o;
  logic [6:0] bytes_left_o;
  logic data_avail_o, fill_err_o;

  always #10 clk = ~clk;

  ifb_line_buffer #(.DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES), .AW(AW), .EW(EW)) u_ifb_line_buffer (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_pc_i(flush_pc_i), .pc_i(pc_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .req_tag_o(req_tag_o), .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i),
    .fill_tag_i(fill_tag_i), .fill_data_i(fill_data_i), .dec_valid_o(dec_valid_o),
    .dec_ready_i(dec_ready_i), .dec_pc_o(dec_pc_o), .dec_word0_o(dec_word0_o),
    .dec_word1_o(dec_word1_o), .dec_len2_o(dec_len2_o), .occupancy_o(occupancy_o),
    .bytes_left_o(bytes_left_o), .data_avail_o(data_avail_o), .fill_err_o(fill_err_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Memory image: unique words, two-word starts at every address ending 0x3C
  function automatic logic [31:0] word_at(logic [31:0] a);
    return {a[31:1], (a[5:0] == 6'h3C)};
  endfunction

  function automatic logic [8*LINE_BYTES-1:0] line_at(logic [31:0] a);
    logic [8*LINE_BYTES-1:0] d;
    for (int w = 0; w < LINE_BYTES/4; w++) d[32*w +: 32] = word_at(a + 32'(4*w));
    return d;
  endfunction

  // Scoreboard
  typedef struct { logic [31:0] pc, w0, w1, nxt; bit two, wrap; } exp_t;
  exp_t sb[$];

  task automatic plan_stream(logic [31:0] start, int n);
    logic [31:0] pc, line0;
    exp_t e;
    pc = start;
    line0 = {start[31:4], 4'h0};
    for (int i = 0; i < n; i++) begin
      e.pc = pc;
      e.w0 = word_at(pc);
      e.w1 = word_at(pc + 4);
      e.two = e.w0[0];
      e.wrap = e.two && ((((pc - line0) >> 2) % 16) == 15);
      e.nxt = pc + (e.two ? 32'd8 : 32'd4);
      sb.push_back(e);
      pc = e.nxt;
    end
  endtask

  // Memory responder: records requests, answers in order
  typedef struct { logic [31:0] addr; logic [EW-1:0] tag; } rq_t;
  rq_t req_q[$];
  bit auto_mem = 0, man_go = 0, seen_140 = 0;
  logic [31:0] man_addr;
  logic [EW-1:0] man_tag;

  initial begin
    rq_t r;
    fill_valid_i = 0; fill_addr_i = '0; fill_tag_i = '0; fill_data_i = '0;
    forever begin
      @(negedge clk);
      fill_valid_i = 0;
      if (man_go) begin
        fill_valid_i = 1; fill_addr_i = man_addr; fill_tag_i = man_tag;
        fill_data_i = line_at(man_addr); man_go = 0;
      end else if (auto_mem && req_q.size() > 0) begin
        r = req_q.pop_front();
        fill_valid_i = 1; fill_addr_i = r.addr; fill_tag_i = r.tag;
        fill_data_i = line_at(r.addr);
      end
      if (rst_n && req_valid_o && req_ready_i) begin
        r.addr = req_addr_o; r.tag = req_tag_o;
        req_q.push_back(r);
        if (req_addr_o == 32'h140) seen_140 = 1;
      end
    end
  end

  // Monitor: pops expected instructions as the decoder consumes them
  bit dec_en = 0;
  logic [31:0] last_nxt = '0;
  initial begin
    exp_t e;
    dec_ready_i = 0; pc_i = '0;
    forever begin
      @(negedge clk);
      dec_ready_i = dec_en && (sb.size() > 0);
      if (dec_ready_i && dec_valid_o) begin
        e = sb.pop_front();
        check(dec_pc_o == e.pc, "R12", "dec_pc", dec_pc_o, e.pc);
        check(dec_word0_o == e.w0, "R3", "word0", dec_word0_o, e.w0);
        check(dec_len2_o == e.two, "R7", "len2", dec_len2_o, e.two);
        if (e.two)
          check(dec_word1_o == e.w1, e.wrap ? "R8" : "R7", "word1", dec_word1_o, e.w1);
        pc_i = e.nxt;
        last_nxt = e.nxt;
      end
    end
  end

  task automatic do_flush(logic [31:0] t);
    @(posedge clk); #1; flush_i = 1; flush_pc_i = t;
    @(posedge clk); #1; flush_i = 0;
  endtask

  task automatic man_fill(logic [31:0] a, logic [EW-1:0] tg);
    @(posedge clk); #1; man_addr = a; man_tag = tg; man_go = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    rq_t r;
    logic [EW-1:0] cur_tag;
    repeat (3) @(negedge clk);
    // R1: idle after reset
    check(!req_valid_o, "R1", "req_valid", req_valid_o, 0);
    check(occupancy_o == 0, "R1", "occupancy", occupancy_o, 0);
    check(bytes_left_o == 0 && !data_avail_o, "R1", "bytes_left", bytes_left_o, 0);
    check(!dec_valid_o && !fill_err_o, "R1", "dec_valid/err", {dec_valid_o, fill_err_o}, 0);
    @(posedge clk); #1; rst_n = 1;
    repeat (2) @(negedge clk);
    check(!req_valid_o, "R1", "idle before flush", req_valid_o, 0);

    // Phase A: redirect mid-line, fill by hand
    do_flush(32'h104);
    @(negedge clk);
    check(req_valid_o, "R2", "req after flush", req_valid_o, 1);
    check(req_addr_o == 32'h100, "R2", "first req addr", req_addr_o, 32'h100);
    check(req_tag_o == 2'd1, "R10", "tag advanced", req_tag_o, 1);
    check(occupancy_o == 0, "R10", "occupancy after flush", occupancy_o, 0);
    repeat (6) @(negedge clk);
    check(occupancy_o == 4, "R5", "occupancy full", occupancy_o, 4);
    check(!req_valid_o, "R2", "no req when full", req_valid_o, 0);
    check(req_q.size() == 4, "R2", "request count", req_q.size(), 4);
    for (int i = 0; i < 4 && i < req_q.size(); i++)
      check(req_q[i].addr == 32'h100 + 32'(16*i), "R2", "consecutive lines",
            req_q[i].addr, 32'h100 + 32'(16*i));
    cur_tag = req_q[0].tag;

    man_fill(32'h110, cur_tag);
    check(fill_err_o, "R4", "error on misordered fill", fill_err_o, 1);
    check(occupancy_o == 4 && bytes_left_o == 0, "R4", "no state change",
          {occupancy_o, bytes_left_o}, {3'd4, 7'd0});
    @(negedge clk);
    check(!fill_err_o, "R4", "error is one cycle", fill_err_o, 0);

    man_fill(32'h100, cur_tag - 2'd1);
    check(!fill_err_o, "R11", "stale fill no error", fill_err_o, 0);
    check(bytes_left_o == 0 && !dec_valid_o, "R11", "stale fill dropped", bytes_left_o, 0);

    r = req_q.pop_front();
    man_fill(r.addr, r.tag);
    check(bytes_left_o == 7'd12, "R6", "bytes after first fill", bytes_left_o, 12);
    check(data_avail_o, "R6", "data_avail", data_avail_o, 1);
    check(dec_valid_o, "R3", "instruction presented", dec_valid_o, 1);
    check(dec_pc_o == 32'h104, "R12", "dec_pc at target", dec_pc_o, 32'h104);
    check(dec_word0_o == word_at(32'h104), "R3", "fill data", dec_word0_o, word_at(32'h104));

    // Phase B: streaming, includes a two-word instruction across the array end
    plan_stream(32'h104, 40);
    @(posedge clk); #1; auto_mem = 1; dec_en = 1;
    wait_drain();
    @(posedge clk); #1; dec_en = 0;
    check(seen_140, "R9", "slot reused after release", seen_140, 1);

    // Phase C: redirect again while streaming had filled the ring
    repeat (3) @(negedge clk);
    sb.delete();
    do_flush(32'h238);
    @(negedge clk);
    check(occupancy_o == 0 && bytes_left_o == 0, "R10", "discard on flush",
          {occupancy_o, bytes_left_o}, 0);
    check(req_addr_o == 32'h230, "R10", "aligned target", req_addr_o, 32'h230);
    plan_stream(32'h238, 24);
    @(posedge clk); #1; dec_en = 1;
    wait_drain();
    @(posedge clk); #1; dec_en = 0;
    repeat (20) @(negedge clk);
    check(occupancy_o == 4, "R9", "ring refilled", occupancy_o, 4);
    check(bytes_left_o == 7'(64 - (last_nxt & 32'hF)), "R6", "bytes left at rest",
          bytes_left_o, 64 - (last_nxt & 32'hF));
    check(!fill_err_o, "R11", "no error from stale fills", fill_err_o, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule